// File: doc/BRIEF.md
# Serial Register Port for a Stereo Volume Controller

This block is the control slave of a stereo volume controller. A host talks to it over three wires: an active-low select, a serial clock and one data line. The data line is split here into an input and a driven-output pair with an enable, which the pad ring turns into a tri-state pin. Every instruction is one 16-bit frame. The first byte names a register and says whether the host reads or writes. The second byte carries the value, either to the block or from it. The block oversamples the serial pins with its own system clock and acts on edges it detects from the synchronised copies.

The block holds five registers: left gain, right gain, peak reference, peak flags and test control. A sixth address is a write-only alias that loads one value into both gain registers. Each gain register has a one-cycle strobe that fires when a write to it commits, so the gain stepping logic knows that a new target has arrived. Two overload inputs set sticky flags. A complete read of the flags register clears the flags it reported. A flag raised while that read is still in progress survives it.

Top module: `vc_serial_regport`

## Requirements
- R1: After reset, left gain, right gain, test control and the flags register read 0x00, the peak reference reads 0xFF and the output enable is low.
- R2: A frame is 16 serial clock rises while select is low, sent MSB first: an address byte, then a data byte. In the address byte, bits 6..3 are the register address and bit 2 is the direction (0 = write, 1 = read). Bits 7, 1 and 0 are ignored. Addresses: 1101 left gain, 1110 right gain, 1100 peak reference, 1111 test control, 1011 flags.
- R3: A write to address 1001 loads the data byte into both gain registers.
- R4: A frame commits only when select rises after exactly 16 rises. A frame with fewer or more rises changes no register, fires no strobe and clears no flag.
- R5: On a read, the 8 bits of the register are driven MSB first. D7 is valid from the 8th falling edge, and each later falling edge moves on one bit. The output enable is low while select is high and during the address byte.
- R6: A read of address 1001, or of any unlisted address, returns 0x00.
- R7: In the flags register, bit 1 is the left overload flag and bit 0 is the right overload flag; the other bits read 0. A one-cycle pulse on an overload input sets its flag on the next clock, and the flag stays set until it is cleared by a read.
- R8: A completed read of the flags register clears exactly the flags it returned. A flag set after the register value was captured stays set.
- R9: When a write commits, a one-cycle strobe fires for each gain register it loads: left for 1101 or 1001, right for 1110 or 1001. A gain register changes only in the cycle its strobe is high.
- R10: Writes to the flags register and to unlisted addresses change no register.
- R11: A read leaves every register except the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Active-low reset |
| ser_clk | input | 1 | Serial clock from the host |
| ser_csn | input | 1 | Active-low frame select |
| ser_din | input | 1 | Serial data from the host |
| ovl_left | input | 1 | Left overload pulse |
| ovl_right | input | 1 | Right overload pulse |
| ser_dout | output | 1 | Serial read data |
| ser_doe | output | 1 | Drive enable for the data line |
| gain_left | output | 8 | Left gain register |
| gain_right | output | 8 | Right gain register |
| peak_ref | output | 8 | Peak reference register |
| test_ctl | output | 8 | Test control register |
| peak_flags | output | 8 | Sticky overload flags |
| gain_left_wr | output | 1 | Strobe: left gain loaded |
| gain_right_wr | output | 1 | Strobe: right gain loaded |

## Verification
The hardest case to reach from the ports is an overload pulse that arrives after the flags value was captured for a read, but before that read commits. The value returned must leave the pulse out, and the flag must still be set afterwards. The bench's frame task can pulse the right overload input just before a chosen serial rise. It uses this to fire the pulse in the middle of the data byte of a flags read, after the left flag alone was set. The read must return 0x02, and the flags must then show 0x01.

// File: rtl/vc_regport_pkg.sv
package vc_regport_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 4;
  localparam int FRAME_BITS = 2 * BYTE_W;

  localparam logic [ADDR_W-1:0] A_LEFT  = 4'b1101;
  localparam logic [ADDR_W-1:0] A_RIGHT = 4'b1110;
  localparam logic [ADDR_W-1:0] A_REF   = 4'b1100;
  localparam logic [ADDR_W-1:0] A_FLAGS = 4'b1011;
  localparam logic [ADDR_W-1:0] A_TEST  = 4'b1111;
  localparam logic [ADDR_W-1:0] A_BOTH  = 4'b1001;

  // register address sits in bits 6..3 of the command byte
  function automatic logic [ADDR_W-1:0] cmd_addr(input logic [BYTE_W-1:0] b);
    return b[6:3];
  endfunction

  // direction flag: bit 2, 1 = read
  function automatic logic cmd_is_read(input logic [BYTE_W-1:0] b);
    return b[2];
  endfunction

  // sticky flag update: reported bits clear, new pulses win
  function automatic logic [1:0] flags_next(input logic [1:0] cur,
                                            input logic [1:0] clr,
                                            input logic [1:0] set);
    return (cur & ~clr) | set;
  endfunction
endpackage

// File: rtl/vc_pin_sync.sv
module vc_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_i,
  input  logic csn_i,
  input  logic din_i,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic cs_act,
  output logic cs_end,
  output logic din_s
);
  localparam int NSIG = 3;
  logic [NSIG-1:0] stage [STAGES];
  logic            sclk_d, csn_d;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stage[s] <= 3'b010;
          else        stage[s] <= {din_i, csn_i, sclk_i};
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stage[s] <= 3'b010;
          else        stage[s] <= stage[s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sclk_d <= 1'b0;
      csn_d  <= 1'b1;
    end else begin
      sclk_d <= stage[STAGES-1][0];
      csn_d  <= stage[STAGES-1][1];
    end

  assign sclk_rise = stage[STAGES-1][0] & ~sclk_d;
  assign sclk_fall = ~stage[STAGES-1][0] & sclk_d;
  assign cs_act    = ~stage[STAGES-1][1];
  assign cs_end    = stage[STAGES-1][1] & ~csn_d;
  assign din_s     = stage[STAGES-1][2];
endmodule

// File: rtl/vc_frame.sv
module vc_frame
  import vc_regport_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              cs_act,
  input  logic              cs_end,
  input  logic              din_s,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              rd_load,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              commit_wr,
  output logic              commit_rd,
  output logic [ADDR_W-1:0] frame_addr,
  output logic [BYTE_W-1:0] frame_data,
  output logic [4:0]        bit_cnt,
  output logic              dout,
  output logic              doe
);
  localparam int CNT_LIM = FRAME_BITS + 1;

  logic [FRAME_BITS-1:0] sr;
  logic [BYTE_W-1:0]     tx;
  logic                  drive;
  logic                  frame_ok;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bit_cnt <= '0;
      sr      <= '0;
    end else if (!cs_act) begin
      bit_cnt <= '0;
    end else if (sclk_rise && bit_cnt != 5'(CNT_LIM)) begin
      bit_cnt <= bit_cnt + 5'd1;
      sr      <= {sr[FRAME_BITS-2:0], din_s};
    end

  assign rd_addr  = cmd_addr(sr[BYTE_W-1:0]);
  assign rd_load  = cs_act && sclk_fall && !drive && bit_cnt == 5'(BYTE_W)
                    && cmd_is_read(sr[BYTE_W-1:0]);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx    <= '0;
      drive <= 1'b0;
    end else if (!cs_act) begin
      drive <= 1'b0;
    end else if (rd_load) begin
      tx    <= rd_data;
      drive <= 1'b1;
    end else if (drive && sclk_fall && bit_cnt > 5'(BYTE_W)
                 && bit_cnt < 5'(FRAME_BITS)) begin
      tx <= {tx[BYTE_W-2:0], 1'b0};
    end

  assign frame_ok   = cs_end && bit_cnt == 5'(FRAME_BITS);
  assign frame_addr = cmd_addr(sr[FRAME_BITS-1:BYTE_W]);
  assign frame_data = sr[BYTE_W-1:0];
  assign commit_wr  = frame_ok && !cmd_is_read(sr[FRAME_BITS-1:BYTE_W]);
  assign commit_rd  = frame_ok &&  cmd_is_read(sr[FRAME_BITS-1:BYTE_W]);
  assign dout       = tx[BYTE_W-1];
  assign doe        = drive & cs_act;
endmodule

// File: rtl/vc_regs.sv
module vc_regs
  import vc_regport_pkg::*;
#(
  parameter logic [BYTE_W-1:0] REF_RESET = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit_wr,
  input  logic              commit_rd,
  input  logic [ADDR_W-1:0] frame_addr,
  input  logic [BYTE_W-1:0] frame_data,
  input  logic              rd_load,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              ovl_left,
  input  logic              ovl_right,
  output logic [BYTE_W-1:0] rd_data,
  output logic [BYTE_W-1:0] gain_left,
  output logic [BYTE_W-1:0] gain_right,
  output logic [BYTE_W-1:0] peak_ref,
  output logic [BYTE_W-1:0] test_ctl,
  output logic [BYTE_W-1:0] peak_flags,
  output logic              gain_left_wr,
  output logic              gain_right_wr
);
  logic [1:0] flags, snap, clr;
  logic       hit_left, hit_right;

  assign hit_left  = commit_wr && (frame_addr == A_LEFT  || frame_addr == A_BOTH);
  assign hit_right = commit_wr && (frame_addr == A_RIGHT || frame_addr == A_BOTH);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      gain_left     <= '0;
      gain_right    <= '0;
      peak_ref      <= REF_RESET;
      test_ctl      <= '0;
      gain_left_wr  <= 1'b0;
      gain_right_wr <= 1'b0;
    end else begin
      gain_left_wr  <= hit_left;
      gain_right_wr <= hit_right;
      if (hit_left)  gain_left  <= frame_data;
      if (hit_right) gain_right <= frame_data;
      if (commit_wr && frame_addr == A_REF)  peak_ref <= frame_data;
      if (commit_wr && frame_addr == A_TEST) test_ctl <= frame_data;
    end

  always_comb begin
    case (rd_addr)
      A_LEFT:  rd_data = gain_left;
      A_RIGHT: rd_data = gain_right;
      A_REF:   rd_data = peak_ref;
      A_TEST:  rd_data = test_ctl;
      A_FLAGS: rd_data = peak_flags;
      default: rd_data = '0;
    endcase
  end

  assign clr = (commit_rd && frame_addr == A_FLAGS) ? snap : 2'b00;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      flags <= '0;
      snap  <= '0;
    end else begin
      flags <= flags_next(flags, clr, {ovl_left, ovl_right});
      if (rd_load) snap <= (rd_addr == A_FLAGS) ? flags : 2'b00;
    end

  assign peak_flags = {{(BYTE_W-2){1'b0}}, flags};
endmodule

// File: rtl/vc_serial_regport.sv
module vc_serial_regport
  import vc_regport_pkg::*;
#(
  parameter int                SYNC_STAGES = 2,
  parameter logic [BYTE_W-1:0] REF_RESET   = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_csn,
  input  logic              ser_din,
  input  logic              ovl_left,
  input  logic              ovl_right,
  output logic              ser_dout,
  output logic              ser_doe,
  output logic [BYTE_W-1:0] gain_left,
  output logic [BYTE_W-1:0] gain_right,
  output logic [BYTE_W-1:0] peak_ref,
  output logic [BYTE_W-1:0] test_ctl,
  output logic [BYTE_W-1:0] peak_flags,
  output logic              gain_left_wr,
  output logic              gain_right_wr
);
  logic              sclk_rise, sclk_fall, cs_act, cs_end, din_s;
  logic              rd_load, commit_wr, commit_rd;
  logic [ADDR_W-1:0] rd_addr, frame_addr;
  logic [BYTE_W-1:0] frame_data, rd_data;
  logic [4:0]        bit_cnt;

  vc_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sclk_i(ser_clk), .csn_i(ser_csn), .din_i(ser_din),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .cs_act(cs_act),
    .cs_end(cs_end), .din_s(din_s)
  );

  vc_frame u_frame (
    .clk(clk), .rst_n(rst_n), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .cs_act(cs_act), .cs_end(cs_end), .din_s(din_s), .rd_data(rd_data),
    .rd_load(rd_load), .rd_addr(rd_addr), .commit_wr(commit_wr),
    .commit_rd(commit_rd), .frame_addr(frame_addr), .frame_data(frame_data),
    .bit_cnt(bit_cnt), .dout(ser_dout), .doe(ser_doe)
  );

  vc_regs #(.REF_RESET(REF_RESET)) u_regs (
    .clk(clk), .rst_n(rst_n), .commit_wr(commit_wr), .commit_rd(commit_rd),
    .frame_addr(frame_addr), .frame_data(frame_data), .rd_load(rd_load),
    .rd_addr(rd_addr), .ovl_left(ovl_left), .ovl_right(ovl_right),
    .rd_data(rd_data), .gain_left(gain_left), .gain_right(gain_right),
    .peak_ref(peak_ref), .test_ctl(test_ctl), .peak_flags(peak_flags),
    .gain_left_wr(gain_left_wr), .gain_right_wr(gain_right_wr)
  );
endmodule

// File: rtl/vc_serial_regport_chk.sv
module vc_serial_regport_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_act,
  input logic       commit_wr,
  input logic       commit_rd,
  input logic [4:0] bit_cnt,
  input logic       ovl_left,
  input logic       ovl_right,
  input logic       ser_doe,
  input logic [7:0] gain_left,
  input logic [7:0] gain_right,
  input logic [7:0] peak_ref,
  input logic [7:0] peak_flags,
  input logic       gain_left_wr,
  input logic       gain_right_wr
);
  assert_quiet_line_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |-> !ser_doe);

  assert_commit_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_wr || commit_rd) |-> bit_cnt == 5'd16);

  assert_left_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !gain_left_wr |-> $stable(gain_left));

  assert_right_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !gain_right_wr |-> $stable(gain_right));

  assert_strobe_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (gain_left_wr || gain_right_wr) |=> !(gain_left_wr || gain_right_wr));

  assert_ref_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_wr |=> $stable(peak_ref));

  assert_left_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ovl_left |=> peak_flags[1]);

  assert_right_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ovl_right |=> peak_flags[0]);

  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (peak_flags[1] && !commit_rd) |=> peak_flags[1]);
endmodule

bind vc_serial_regport vc_serial_regport_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .commit_wr(commit_wr),
  .commit_rd(commit_rd), .bit_cnt(bit_cnt), .ovl_left(ovl_left),
  .ovl_right(ovl_right), .ser_doe(ser_doe), .gain_left(gain_left),
  .gain_right(gain_right), .peak_ref(peak_ref), .peak_flags(peak_flags),
  .gain_left_wr(gain_left_wr), .gain_right_wr(gain_right_wr)
);

// File: tb/tb_vc_serial_regport.sv
module tb_vc_serial_regport;
  localparam int HALF = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_csn = 1'b1, ser_din = 1'b0;
  logic ovl_left = 1'b0, ovl_right = 1'b0;
  logic ser_dout, ser_doe, gain_left_wr, gain_right_wr;
  logic [7:0] gain_left, gain_right, peak_ref, test_ctl, peak_flags;
  int total = 0, bad = 0;
  int n_sl = 0, n_sr = 0;
  logic [7:0] rd;

  always #10 clk = ~clk;

  vc_serial_regport dut (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_csn(ser_csn),
    .ser_din(ser_din), .ovl_left(ovl_left), .ovl_right(ovl_right),
    .ser_dout(ser_dout), .ser_doe(ser_doe), .gain_left(gain_left),
    .gain_right(gain_right), .peak_ref(peak_ref), .test_ctl(test_ctl),
    .peak_flags(peak_flags), .gain_left_wr(gain_left_wr),
    .gain_right_wr(gain_right_wr)
  );

  always @(negedge clk) begin
    if (gain_left_wr)  n_sl++;
    if (gain_right_wr) n_sr++;
  end

  typedef struct packed {
    logic [7:0] a, d, gl, gr, rf, ts;
    logic       sl, sr;
  } vec_t;

  localparam vec_t VT [8] = '{
    '{8'h68, 8'h55, 8'h55, 8'h00, 8'hFF, 8'h00, 1'b1, 1'b0},
    '{8'h70, 8'hA3, 8'h55, 8'hA3, 8'hFF, 8'h00, 1'b0, 1'b1},
    '{8'h48, 8'h3C, 8'h3C, 8'h3C, 8'hFF, 8'h00, 1'b1, 1'b1},
    '{8'hEB, 8'h12, 8'h12, 8'h3C, 8'hFF, 8'h00, 1'b1, 1'b0},
    '{8'h60, 8'h80, 8'h12, 8'h3C, 8'h80, 8'h00, 1'b0, 1'b0},
    '{8'h78, 8'h06, 8'h12, 8'h3C, 8'h80, 8'h06, 1'b0, 1'b0},
    '{8'h58, 8'hFF, 8'h12, 8'h3C, 8'h80, 8'h06, 1'b0, 1'b0},
    '{8'h00, 8'hAA, 8'h12, 8'h3C, 8'h80, 8'h06, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // nbits serial rises; pulse_bit fires ovl_right before that rise (-1: none)
  task automatic xfer(input logic [7:0] a, input logic [7:0] d, input int nbits,
                      input int pulse_bit, output logic [7:0] rdat);
    logic [15:0] w;
    w = {a, d};
    rdat = '0;
    ser_csn = 1'b0;
    wait_clk(HALF);
    for (int i = 0; i < nbits; i++) begin
      ser_din = (i < 16) ? w[15-i] : 1'b0;
      if (i == pulse_bit) begin
        ovl_right = 1'b1;
        wait_clk(1);
        ovl_right = 1'b0;
        wait_clk(HALF - 1);
      end else begin
        wait_clk(HALF);
      end
      if (i >= 8 && i < 16) rdat[15-i] = ser_dout;
      if (i == 4) chk("R5 enable low in address byte", {7'd0, ser_doe}, 8'h00);
      if (i == 12 && a[2]) chk("R5 enable high in data byte", {7'd0, ser_doe}, 8'h01);
      ser_clk = 1'b1;
      wait_clk(HALF);
      ser_clk = 1'b0;
    end
    wait_clk(HALF);
    ser_csn = 1'b1;
    wait_clk(8);
  endtask

  initial begin
    int sl0, sr0;
    fork
      begin
        wait_clk(150000);
        bad++; total++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    join_none

    wait_clk(4);
    // R1 reset values
    chk("R1 left", gain_left, 8'h00);
    chk("R1 right", gain_right, 8'h00);
    chk("R1 ref", peak_ref, 8'hFF);
    chk("R1 test", test_ctl, 8'h00);
    chk("R1 flags", peak_flags, 8'h00);
    chk("R1 oe", {7'd0, ser_doe}, 8'h00);
    rst_n = 1'b1;
    wait_clk(4);

    // R2 R3 R9 R10: table walk
    for (int k = 0; k < 8; k++) begin
      sl0 = n_sl; sr0 = n_sr;
      xfer(VT[k].a, VT[k].d, 16, -1, rd);
      chk("R2/R3 left gain", gain_left, VT[k].gl);
      chk("R2/R3 right gain", gain_right, VT[k].gr);
      chk("R2/R10 ref", peak_ref, VT[k].rf);
      chk("R2/R10 test", test_ctl, VT[k].ts);
      chk("R10 flags", peak_flags, 8'h00);
      chk("R9 left strobes", 8'(n_sl - sl0), {7'd0, VT[k].sl});
      chk("R9 right strobes", 8'(n_sr - sr0), {7'd0, VT[k].sr});
    end

    // R5 R11 reads
    xfer(8'h6C, 8'h00, 16, -1, rd);
    chk("R5 read left", rd, 8'h12);
    xfer(8'h64, 8'h00, 16, -1, rd);
    chk("R5 read ref", rd, 8'h80);
    xfer(8'h7C, 8'hFF, 16, -1, rd);
    chk("R5 read test", rd, 8'h06);
    chk("R11 left kept", gain_left, 8'h12);
    chk("R11 ref kept", peak_ref, 8'h80);
    chk("R5 oe low after frame", {7'd0, ser_doe}, 8'h00);

    // R6 alias and unlisted reads
    xfer(8'h4C, 8'h00, 16, -1, rd);
    chk("R6 alias read", rd, 8'h00);
    xfer(8'h04, 8'h00, 16, -1, rd);
    chk("R6 unlisted read", rd, 8'h00);
    chk("R6 gains kept", gain_right, 8'h3C);

    // R4 short and long frames
    sl0 = n_sl;
    xfer(8'h68, 8'hEE, 10, -1, rd);
    chk("R4 short write discarded", gain_left, 8'h12);
    xfer(8'h68, 8'h77, 17, -1, rd);
    chk("R4 long write discarded", gain_left, 8'h12);
    chk("R4 no strobe", 8'(n_sl - sl0), 8'h00);

    // R7 sticky flags
    ovl_left = 1'b1; wait_clk(1); ovl_left = 1'b0;
    wait_clk(20);
    chk("R7 left flag sticky", peak_flags, 8'h02);

    // R8 pulse during read survives
    xfer(8'h5C, 8'h00, 16, 12, rd);
    chk("R8 read value", rd, 8'h02);
    chk("R8 late flag kept", peak_flags, 8'h01);
    xfer(8'h5C, 8'h00, 16, -1, rd);
    chk("R8 second read", rd, 8'h01);
    chk("R8 cleared", peak_flags, 8'h00);

    // R4 aborted flags read clears nothing
    ovl_left = 1'b1; ovl_right = 1'b1; wait_clk(1);
    ovl_left = 1'b0; ovl_right = 1'b0; wait_clk(2);
    chk("R7 both flags", peak_flags, 8'h03);
    xfer(8'h5C, 8'h00, 12, -1, rd);
    chk("R4 aborted read keeps flags", peak_flags, 8'h03);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule